// File: doc/BRIEF.md
# Reset Release Sequencer

This block decides when a processor core may leave reset, either after power is applied or after it wakes from a low-power state. It holds an internal reset output high and walks through up to three waits, chosen by the clock-source mode and by the kind of reset. The first wait is a power-up wait counted on ticks of a slow internal clock. The second is a crystal settling wait counted on ticks of the external oscillator. The third is a frequency-multiplier lock wait, counted again on slow ticks. Ticks arrive as one-cycle enables on the block clock.

The waits are timed from the end of the power-on pulse, whatever the external reset pin is doing. If the pin is still low when the last wait has ended, the sequencer parks in a hold state. Raising the pin then releases the core within the synchronizer latency. A wake request or a low pin while running starts the sequence again. A power-on pulse forces the block back to its start at any time.

The sequencer states are Idle (code 0), Power-up (1), Oscillator settle (2), Lock (3), Pin hold (4) and Run (5). From Idle it goes to Power-up on a cold start with the power-up wait enabled. Otherwise it goes to Oscillator settle for a crystal mode, and to Pin hold for any other mode. Power-up goes on to Oscillator settle, or for a non-crystal mode to Pin hold. Oscillator settle goes on to Lock in the multiplied-crystal mode, and to Pin hold in the other crystal modes. Lock goes to Pin hold. Pin hold goes to Run once the synchronized pin is high. Run returns to Idle on a low pin (cold) or on a wake request (warm).

Top module: `rrs_top`

## Requirements
- R1: While `por_pulse` is high, `core_rst` is 1 and `seq_state` is 0 (Idle). `core_rst` rises without waiting for a clock edge when `por_pulse` rises or `ext_rst_n` falls.
- R2: On a cold start with `pup_off`=0, the sequencer stays in state 1 with `core_rst`=1 until `PUP_TICKS` pulses of `slow_tick` have been counted.
- R3: With `pup_off`=1, the power-up wait is skipped. A crystal mode goes straight to state 2.
- R4: For `osc_mode` codes 0, 1, 2 and 3 (low, mid, high and multiplied crystal), state 2 follows the power-up wait and counts `OSC_CYCLES` pulses of `osc_tick`. Pulses of `osc_tick` that arrive during state 1 are not counted.
- R5: For codes 4 (external clock), 5 (RC), 6 (internal oscillator) and the unused code 7, no oscillator wait is done.
- R6: Only code 3 adds state 3 after state 2, and that state counts `LOCK_TICKS` pulses of `slow_tick`.
- R7: A `wake_req` pulse in state 5 raises `core_rst` and runs a warm sequence. The warm sequence never enters state 1, and it runs states 2 and 3 as the latched mode requires.
- R8: If `ext_rst_n` is held low, the waits still run and the sequencer waits in state 4. After the pin goes high, state 5 with `core_rst`=0 follows within 4 clock cycles.
- R9: A low `ext_rst_n` in state 5 raises `core_rst` at once and restarts a cold sequence, including the power-up wait.
- R10: `seq_state` shows the encoding 0..5 listed above. `core_rst` is 0 only in state 5.
- R11: With `pup_off`=1 and a non-crystal mode, `core_rst` falls within 4 clock cycles after `por_pulse` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wake_req | input | 1 | Wake from low-power state, one-cycle pulse |
| osc_mode | input | 3 | Clock-source mode code (0..7) |
| pup_off | input | 1 | 1 skips the power-up wait |
| slow_tick | input | 1 | Slow internal clock enable pulse |
| osc_tick | input | 1 | External oscillator enable pulse |
| core_rst | output | 1 | Reset to the core, active high |
| seq_state | output | 3 | Current sequencer state code |

## Verification
The sequence is driven with several mode and enable combinations. A high-crystal cold start with the power-up wait exercises both the first and second waits, with oscillator ticks sent during the first to show they are not counted. A multiplied-crystal start without the power-up wait checks the lock stage, and RC, internal and unused codes show that the oscillator wait is skipped. Tick counts of one below each limit and then at the limit tell an off-by-one count apart from a correct one. Wake, a pin held low through the waits and a pin dropped in Run separate the warm path, the cold path and the pin hold.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PUP  = 3'd1,
        ST_OSC  = 3'd2,
        ST_LOCK = 3'd3,
        ST_HOLD = 3'd4,
        ST_RUN  = 3'd5
    } seq_state_t;

    typedef enum logic [2:0] {
        MODE_XTAL_LOW  = 3'd0,
        MODE_XTAL_MID  = 3'd1,
        MODE_XTAL_HIGH = 3'd2,
        MODE_XTAL_MUL  = 3'd3,
        MODE_EXT_CLK   = 3'd4,
        MODE_RC        = 3'd5,
        MODE_INT_OSC   = 3'd6,
        MODE_SPARE     = 3'd7
    } osc_mode_t;

    // crystal modes need a settling count
    function automatic logic mode_needs_osc(input logic [2:0] m);
        return (m == MODE_XTAL_LOW) || (m == MODE_XTAL_MID) ||
               (m == MODE_XTAL_HIGH) || (m == MODE_XTAL_MUL);
    endfunction

    // only the multiplied crystal waits for lock
    function automatic logic mode_needs_lock(input logic [2:0] m);
        return (m == MODE_XTAL_MUL);
    endfunction

endpackage

// File: rtl/rrs_sync.sv
module rrs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or posedge arst) begin
                if (arst) sr <= '0;
                else      sr <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or posedge arst) begin
                if (arst) sr <= '0;
                else      sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/rrs_tick_counter.sv
module rrs_tick_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic arst,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(LIMIT));

    always_ff @(posedge clk or posedge arst) begin
        if (arst)               cnt <= '0;
        else if (clear)         cnt <= '0;
        else if (tick && !done) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rrs_fsm.sv
module rrs_fsm
    import rrs_pkg::*;
(
    input  logic       clk,
    input  logic       por_pulse,
    input  logic       ext_rst_n,
    input  logic       pin_ok,
    input  logic       wake_req,
    input  logic [2:0] osc_mode,
    input  logic       pup_off,
    input  logic       pup_done,
    input  logic       osc_done,
    input  logic       lock_done,
    output seq_state_t state,
    output logic       cold_q,
    output logic       core_rst
);
    seq_state_t nxt;
    logic [2:0] mode_q;
    logic       force_rst;

    assign force_rst = por_pulse | ~ext_rst_n;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cold_q && !pup_off)            nxt = ST_PUP;
                else if (mode_needs_osc(osc_mode)) nxt = ST_OSC;
                else                               nxt = ST_HOLD;
            end
            ST_PUP: begin
                if (pup_done) nxt = mode_needs_osc(mode_q) ? ST_OSC : ST_HOLD;
            end
            ST_OSC: begin
                if (osc_done) nxt = mode_needs_lock(mode_q) ? ST_LOCK : ST_HOLD;
            end
            ST_LOCK: begin
                if (lock_done) nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (pin_ok) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!pin_ok || wake_req) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register with latched mode and restart kind
    always_ff @(posedge clk or posedge por_pulse) begin
        if (por_pulse) begin
            state  <= ST_IDLE;
            mode_q <= MODE_EXT_CLK;
            cold_q <= 1'b1;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) mode_q <= osc_mode;
            if (state == ST_RUN) begin
                if (!pin_ok)       cold_q <= 1'b1;
                else if (wake_req) cold_q <= 1'b0;
            end
        end
    end

    // output register: asynchronous set, synchronous release
    always_ff @(posedge clk or posedge force_rst) begin
        if (force_rst) core_rst <= 1'b1;
        else           core_rst <= (nxt != ST_RUN);
    end
endmodule

// File: rtl/rrs_top.sv
module rrs_top
    import rrs_pkg::*;
#(
    parameter int PUP_TICKS   = 2048,
    parameter int OSC_CYCLES  = 1024,
    parameter int LOCK_TICKS  = 63,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_pulse,
    input  logic       ext_rst_n,
    input  logic       wake_req,
    input  logic [2:0] osc_mode,
    input  logic       pup_off,
    input  logic       slow_tick,
    input  logic       osc_tick,
    output logic       core_rst,
    output logic [2:0] seq_state
);
    seq_state_t state;
    logic pin_ok;
    logic kind_cold;
    logic pup_done, osc_done, lock_done;

    rrs_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
        .clk (clk),
        .arst(por_pulse),
        .d   (ext_rst_n),
        .q   (pin_ok)
    );

    rrs_tick_counter #(.LIMIT(PUP_TICKS)) i_pup_cnt (
        .clk  (clk),
        .arst (por_pulse),
        .clear(state != ST_PUP),
        .tick (slow_tick),
        .done (pup_done)
    );

    rrs_tick_counter #(.LIMIT(OSC_CYCLES)) i_osc_cnt (
        .clk  (clk),
        .arst (por_pulse),
        .clear(state != ST_OSC),
        .tick (osc_tick),
        .done (osc_done)
    );

    rrs_tick_counter #(.LIMIT(LOCK_TICKS)) i_lock_cnt (
        .clk  (clk),
        .arst (por_pulse),
        .clear(state != ST_LOCK),
        .tick (slow_tick),
        .done (lock_done)
    );

    rrs_fsm i_fsm (
        .clk      (clk),
        .por_pulse(por_pulse),
        .ext_rst_n(ext_rst_n),
        .pin_ok   (pin_ok),
        .wake_req (wake_req),
        .osc_mode (osc_mode),
        .pup_off  (pup_off),
        .pup_done (pup_done),
        .osc_done (osc_done),
        .lock_done(lock_done),
        .state    (state),
        .cold_q   (kind_cold),
        .core_rst (core_rst)
    );

    assign seq_state = state;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker
    import rrs_pkg::*;
(
    input logic       clk,
    input logic       por_pulse,
    input logic       core_rst,
    input logic [2:0] seq_state,
    input logic       pin_ok,
    input logic       cold
);
    // R10: reset held in every state but run
    assert_rst_outside_run_R10: assert property (@(posedge clk) disable iff (por_pulse)
        (seq_state != ST_RUN) |-> core_rst);

    // R2: power-up state only leaves toward the settle or hold state
    assert_pup_exit_R2: assert property (@(posedge clk) disable iff (por_pulse)
        (seq_state == ST_PUP) |=> (seq_state == ST_PUP || seq_state == ST_OSC || seq_state == ST_HOLD));

    // R6: lock entered only from the settle state
    assert_lock_after_osc_R6: assert property (@(posedge clk) disable iff (por_pulse)
        (seq_state == ST_LOCK && $past(seq_state) != ST_LOCK) |-> $past(seq_state) == ST_OSC);

    // R8: run entered only from pin hold
    assert_run_from_hold_R8: assert property (@(posedge clk) disable iff (por_pulse)
        (seq_state == ST_RUN && $past(seq_state) != ST_RUN) |-> $past(seq_state) == ST_HOLD);

    // R8: release only with the synchronized pin high
    assert_release_needs_pin_R8: assert property (@(posedge clk) disable iff (por_pulse)
        $fell(core_rst) |-> $past(pin_ok));

    // R7: a warm restart never enters the power-up wait
    assert_no_pup_on_wake_R7: assert property (@(posedge clk) disable iff (por_pulse)
        (seq_state == ST_PUP) |-> cold);
endmodule

bind rrs_top rrs_checker i_rrs_checker (
    .clk      (clk),
    .por_pulse(por_pulse),
    .core_rst (core_rst),
    .seq_state(seq_state),
    .pin_ok   (pin_ok),
    .cold     (kind_cold)
);

// File: tb/test_rrs_top.sv
module test_rrs_top;
    localparam int PUP = 16;
    localparam int OSC = 8;
    localparam int LCK = 4;

    logic       clk = 1'b0;
    logic       por_pulse = 1'b1;
    logic       ext_rst_n = 1'b1;
    logic       wake_req = 1'b0;
    logic [2:0] osc_mode = 3'd2;
    logic       pup_off = 1'b0;
    logic       slow_tick = 1'b0;
    logic       osc_tick = 1'b0;
    logic       core_rst;
    logic [2:0] seq_state;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rrs_top #(.PUP_TICKS(PUP), .OSC_CYCLES(OSC), .LOCK_TICKS(LCK)) i_rrs_top (
        .clk(clk), .por_pulse(por_pulse), .ext_rst_n(ext_rst_n), .wake_req(wake_req),
        .osc_mode(osc_mode), .pup_off(pup_off), .slow_tick(slow_tick), .osc_tick(osc_tick),
        .core_rst(core_rst), .seq_state(seq_state)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1'b1; @(negedge clk);
            slow_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic osc(input int n);
        for (int i = 0; i < n; i++) begin
            osc_tick = 1'b1; @(negedge clk);
            osc_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic power_up(input logic [2:0] mode, input logic off);
        @(negedge clk);
        por_pulse = 1'b1; osc_mode = mode; pup_off = off;
        idle(3);
        por_pulse = 1'b0;
    endtask

    task automatic t_reset;
        chk(core_rst, 1, "R1 core_rst during power-on pulse");
        chk(seq_state, 0, "R1 state idle during power-on pulse");
    endtask

    task automatic t_high_crystal;
        power_up(3'd2, 1'b0);
        idle(3);
        chk(seq_state, 1, "R2 enters power-up wait");
        osc(OSC);
        chk(seq_state, 1, "R4 osc ticks ignored during power-up");
        slow(PUP - 1);
        idle(2);
        chk(seq_state, 1, "R2 one tick short");
        chk(core_rst, 1, "R2 reset held");
        slow(1); idle(2);
        chk(seq_state, 2, "R4 settle follows power-up");
        osc(OSC - 1); idle(2);
        chk(seq_state, 2, "R4 one osc tick short");
        osc(1); idle(2);
        chk(seq_state, 5, "R10 run after settle");
        chk(core_rst, 0, "R10 released in run");
    endtask

    task automatic t_pll;
        power_up(3'd3, 1'b1);
        idle(3);
        chk(seq_state, 2, "R3 power-up skipped");
        osc(OSC); idle(2);
        chk(seq_state, 3, "R6 lock after settle");
        slow(LCK - 1); idle(2);
        chk(seq_state, 3, "R6 one lock tick short");
        slow(1); idle(2);
        chk(seq_state, 5, "R6 run after lock");
    endtask

    task automatic t_wake;
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        chk(core_rst, 1, "R7 wake raises reset");
        idle(2);
        chk(seq_state, 2, "R7 warm start goes to settle");
        osc(OSC); slow(LCK); idle(2);
        chk(seq_state, 5, "R7 warm sequence reaches run");
    endtask

    task automatic t_no_osc(input logic [2:0] mode, input string tag);
        power_up(mode, 1'b0);
        idle(3);
        chk(seq_state, 1, {tag, " power-up wait"});
        slow(PUP); idle(3);
        chk(seq_state, 5, {tag, " no settle stage"});
    endtask

    task automatic t_no_delay(input logic [2:0] mode, input string tag);
        power_up(mode, 1'b1);
        idle(4);
        chk(core_rst, 0, tag);
    endtask

    task automatic t_pin;
        ext_rst_n = 1'b0;
        #1;
        chk(core_rst, 1, "R9 asynchronous assert on pin low");
        @(negedge clk);
        idle(4);
        chk(seq_state, 1, "R9 cold restart with power-up wait");
        slow(PUP); idle(3);
        chk(seq_state, 4, "R8 waits in pin hold");
        idle(20);
        chk(core_rst, 1, "R8 reset held while pin low");
        ext_rst_n = 1'b1;
        idle(4);
        chk(seq_state, 5, "R8 run soon after pin release");
        chk(core_rst, 0, "R8 release after pin high");
    endtask

    initial begin
        idle(2);
        t_reset;
        t_high_crystal;
        t_pll;
        t_wake;
        t_no_osc(3'd5, "R5 RC");
        t_no_osc(3'd7, "R5 spare code");
        t_no_delay(3'd6, "R11 internal oscillator no delay");
        t_no_delay(3'd4, "R11 external clock no delay");
        t_no_osc(3'd4, "R5 external clock");
        t_pin;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule